// File: doc/BRIEF.md
# Per-Device Interrupt Line Router

This block takes one interrupt request from each of several logical devices and places it on one of fifteen shared, active-high interrupt lines. Each device owns a 4-bit line-select register. A select of zero means the device is not routed. A select of 1 to 15 picks interrupt line 1 to 15. The host reaches these registers through a configuration index/data pair. Only the index given by the `SEL_INDEX` parameter (0x70 by default) decodes to the line-select registers. The device number chooses which device's register is accessed.

A route is live only while the device's enable qualifier input is high. The qualifier is built outside the block from the device's own control bits, such as a DMA enable or an IRQ enable. When several live devices pick the same line, the line carries the OR of their requests. A line's output enable is high while at least one live device claims that line, and low otherwise, so an unclaimed line floats. Line 2 shares its pin with an active-low system-management interrupt. While `smi_en` is high, that pin always carries the inverted `smi_req` and is never used as interrupt line 2.

Four resets reload the select registers. Three are asynchronous and active-low: main-supply power-on, standby-supply power-on and bus reset. The fourth is a synchronous soft reset. Device 0 resets to 6 and every other device resets to 0. The pin values and output enables are registered, so each pin changes exactly one clock after its inputs.

Top module: `irq_line_router`

## Requirements
- R1: Each device's line-select register is 4 bits wide. A read at the select index returns it in bits [3:0] with bits [7:4] as zero, and a write keeps only `cfg_wdata[3:0]`.
- R2: When any of `por_main_n`, `por_stby_n` or `bus_rst_n` is low, or `soft_rst` is high at a clock edge, device 0's select becomes 6 and every other device's select becomes 0.
- R3: A device whose select is 0 drives no line. A device whose select is k (1 to 15) is routed to line k, which is bit k-1 of `irq_o`/`irq_oe`.
- R4: A device whose `dev_qual` bit is low claims no line, so its request and its select have no effect on the pins.
- R5: The value of a routed line is the OR of `dev_req` over all live devices that select it, with logic 1 meaning a request is active.
- R6: A line's `irq_oe` bit is 1 when at least one live device selects that line, even if no request is pending, and is 0 otherwise.
- R7: While `smi_en` is 1, bit 1 of `irq_o` equals the inverse of `smi_req`, bit 1 of `irq_oe` is 1, and device routes to line 2 are ignored.
- R8: While `smi_en` is 0, line 2 is routed like every other line.
- R9: `irq_o` and `irq_oe` are registered. They reflect the inputs and selects present at the previous clock edge, and all three asynchronous resets clear them to 0.
- R10: Any line whose `irq_oe` bit is 0 has its `irq_o` bit at 0.
- R11: A write at any index other than the select index changes no select register. A read at any other index returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_main_n | input | 1 | Main-supply power-on reset, asynchronous, active-low |
| por_stby_n | input | 1 | Standby-supply power-on reset, asynchronous, active-low |
| bus_rst_n | input | 1 | Host bus reset, asynchronous, active-low |
| soft_rst | input | 1 | Synchronous soft reset of the select registers |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_index | input | 8 | Configuration register index |
| cfg_dev | input | DEV_W (2) | Logical device number being accessed |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| dev_req | input | NUM_DEV (4) | Per-device interrupt request, active-high |
| dev_qual | input | NUM_DEV (4) | Per-device route enable qualifier |
| smi_en | input | 1 | Gives the line-2 pin to the management interrupt |
| smi_req | input | 1 | Management interrupt request, active-high |
| irq_o | output | 15 | Line values; bit k-1 is line k |
| irq_oe | output | 15 | Line output enables; bit k-1 is line k |

## Verification
A corrupted select register is visible at once on `cfg_rdata`. On the pins it shows one clock later, either as a request on the wrong line or as a wrong output enable. A stuck or misdecoded qualifier or merge term shows on the next edge after the request pattern changes. The bench therefore compares both pin vectors with an independent model after every clock. A fault in the line-2 sharing shows within one cycle of toggling `smi_en` or `smi_req`. A wrong reset default shows on the first read after any of the four resets.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int SEL_W    = 4;
  localparam int DATA_W   = 8;
  localparam int LINE_CNT = (1 << SEL_W) - 1;

  typedef logic [SEL_W-1:0] sel_t;

  // reset value of one device's select register
  function automatic sel_t reset_sel(int dev, sel_t dev0_val);
    return (dev == 0) ? dev0_val : '0;
  endfunction
endpackage

// File: rtl/irq_sel_bank.sv
module irq_sel_bank
  import irq_router_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int DEV_W = 2,
  parameter int DEV0_DEFAULT = 6,
  parameter logic [DATA_W-1:0] SEL_INDEX = 8'h70
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     soft_rst,
  input  logic                     cfg_we,
  input  logic [DATA_W-1:0]        cfg_index,
  input  logic [DEV_W-1:0]         cfg_dev,
  input  logic [DATA_W-1:0]        cfg_wdata,
  output logic [DATA_W-1:0]        cfg_rdata,
  output logic [NUM_DEV*SEL_W-1:0] sel_flat
);
  localparam sel_t DEV0_SEL = sel_t'(DEV0_DEFAULT);

  logic hit;
  logic unused_wr_hi;
  sel_t rd_sel;

  assign hit          = (cfg_index == SEL_INDEX);
  assign unused_wr_hi = ^cfg_wdata[DATA_W-1:SEL_W];

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    sel_t sel_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sel_q <= reset_sel(d, DEV0_SEL);
      else if (soft_rst)
        sel_q <= reset_sel(d, DEV0_SEL);
      else if (cfg_we && hit && (cfg_dev == DEV_W'(d)))
        sel_q <= cfg_wdata[SEL_W-1:0];
    end
    assign sel_flat[d*SEL_W +: SEL_W] = sel_q;
  end

  always_comb begin
    rd_sel = '0;
    for (int d = 0; d < NUM_DEV; d++)
      if (cfg_dev == DEV_W'(d)) rd_sel = sel_flat[d*SEL_W +: SEL_W];
    cfg_rdata = hit ? {{(DATA_W-SEL_W){1'b0}}, rd_sel} : '0;
  end
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
  import irq_router_pkg::*;
#(
  parameter int NUM_DEV = 4
) (
  input  logic [NUM_DEV*SEL_W-1:0] sel_flat,
  input  logic [NUM_DEV-1:0]       dev_req,
  input  logic [NUM_DEV-1:0]       dev_qual,
  output logic [LINE_CNT-1:0]      line_req,
  output logic [LINE_CNT-1:0]      line_claim
);
  for (genvar l = 0; l < LINE_CNT; l++) begin : g_line
    logic [NUM_DEV-1:0] live;
    always_comb begin
      for (int d = 0; d < NUM_DEV; d++)
        live[d] = dev_qual[d] && (sel_flat[d*SEL_W +: SEL_W] == SEL_W'(l + 1));
    end
    assign line_claim[l] = |live;
    assign line_req[l]   = |(live & dev_req);
  end
endmodule

// File: rtl/irq_pin_stage.sv
module irq_pin_stage
  import irq_router_pkg::*;
#(
  parameter int SMI_CODE = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smi_en,
  input  logic                smi_req,
  input  logic [LINE_CNT-1:0] line_req,
  input  logic [LINE_CNT-1:0] line_claim,
  output logic [LINE_CNT-1:0] irq_o,
  output logic [LINE_CNT-1:0] irq_oe
);
  for (genvar l = 0; l < LINE_CNT; l++) begin : g_pin
    logic nxt_val, nxt_oe;
    if (l + 1 == SMI_CODE) begin : g_shared
      assign nxt_val = smi_en ? !smi_req : line_req[l];
      assign nxt_oe  = smi_en | line_claim[l];
    end else begin : g_plain
      assign nxt_val = line_req[l];
      assign nxt_oe  = line_claim[l];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irq_o[l]  <= 1'b0;
        irq_oe[l] <= 1'b0;
      end else begin
        irq_o[l]  <= nxt_val;
        irq_oe[l] <= nxt_oe;
      end
    end
  end
endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
  import irq_router_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int DEV0_DEFAULT = 6,
  parameter logic [7:0] SEL_INDEX = 8'h70,
  localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               por_main_n,
  input  logic               por_stby_n,
  input  logic               bus_rst_n,
  input  logic               soft_rst,
  input  logic               cfg_we,
  input  logic [7:0]         cfg_index,
  input  logic [DEV_W-1:0]   cfg_dev,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_rdata,
  input  logic [NUM_DEV-1:0] dev_req,
  input  logic [NUM_DEV-1:0] dev_qual,
  input  logic               smi_en,
  input  logic               smi_req,
  output logic [14:0]        irq_o,
  output logic [14:0]        irq_oe
);
  logic                     rst_n;
  logic [NUM_DEV*SEL_W-1:0] sel_flat;
  logic [LINE_CNT-1:0]      line_req, line_claim;

  assign rst_n = por_main_n & por_stby_n & bus_rst_n;

  irq_sel_bank #(
    .NUM_DEV(NUM_DEV), .DEV_W(DEV_W),
    .DEV0_DEFAULT(DEV0_DEFAULT), .SEL_INDEX(SEL_INDEX)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .cfg_we(cfg_we), .cfg_index(cfg_index), .cfg_dev(cfg_dev),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sel_flat(sel_flat)
  );

  irq_route_matrix #(.NUM_DEV(NUM_DEV)) u_matrix (
    .sel_flat(sel_flat), .dev_req(dev_req), .dev_qual(dev_qual),
    .line_req(line_req), .line_claim(line_claim)
  );

  irq_pin_stage #(.SMI_CODE(2)) u_pins (
    .clk(clk), .rst_n(rst_n), .smi_en(smi_en), .smi_req(smi_req),
    .line_req(line_req), .line_claim(line_claim),
    .irq_o(irq_o), .irq_oe(irq_oe)
  );
endmodule

// File: rtl/irq_line_router_chk.sv
module irq_line_router_chk
  import irq_router_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int DEV0_DEFAULT = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     soft_rst,
  input logic                     cfg_we,
  input logic [7:0]               cfg_rdata,
  input logic [NUM_DEV-1:0]       dev_req,
  input logic [NUM_DEV-1:0]       dev_qual,
  input logic                     smi_en,
  input logic                     smi_req,
  input logic [14:0]              irq_o,
  input logic [14:0]              irq_oe,
  input logic [NUM_DEV*SEL_W-1:0] sel_flat
);
  localparam sel_t DEV0_SEL = sel_t'(DEV0_DEFAULT);

  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7:4] == 4'h0); // R1

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_chk
    AST_SOFT_RESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> sel_flat[d*SEL_W +: SEL_W] == reset_sel(d, DEV0_SEL)); // R2
  end

  AST_UNCLAIMED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|dev_qual) && !smi_en) |=> irq_oe == '0); // R4

  AST_QUIET_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|dev_req) && !smi_en) |=> irq_o == '0); // R5

  AST_SMI_OWNS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    smi_en |=> (irq_oe[1] && (irq_o[1] == !$past(smi_req)))); // R7

  AST_DATA_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~irq_oe) == '0); // R10

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !soft_rst) |=> $stable(sel_flat)); // R11
endmodule

bind irq_line_router irq_line_router_chk #(
  .NUM_DEV(NUM_DEV), .DEV0_DEFAULT(DEV0_DEFAULT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_we(cfg_we),
  .cfg_rdata(cfg_rdata), .dev_req(dev_req), .dev_qual(dev_qual),
  .smi_en(smi_en), .smi_req(smi_req), .irq_o(irq_o), .irq_oe(irq_oe),
  .sel_flat(sel_flat)
);

// File: tb/irq_line_router_test.sv
module irq_line_router_test;
  logic        clk = 1'b0;
  logic        por_main_n = 1'b0, por_stby_n = 1'b1, bus_rst_n = 1'b1;
  logic        soft_rst = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_index = 8'h00;
  logic [1:0]  cfg_dev = 2'd0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [3:0]  dev_req = 4'h0, dev_qual = 4'h0;
  logic        smi_en = 1'b0, smi_req = 1'b0;
  logic [14:0] irq_o, irq_oe;

  logic [3:0]  mdl [4];
  int          n_vec = 0, n_bad = 0;
  bit          done = 0;

  irq_line_router uut (
    .clk(clk), .por_main_n(por_main_n), .por_stby_n(por_stby_n),
    .bus_rst_n(bus_rst_n), .soft_rst(soft_rst), .cfg_we(cfg_we),
    .cfg_index(cfg_index), .cfg_dev(cfg_dev), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .dev_req(dev_req), .dev_qual(dev_qual),
    .smi_en(smi_en), .smi_req(smi_req), .irq_o(irq_o), .irq_oe(irq_oe)
  );

  always #2 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic load_defaults();
    mdl[0] = 4'd6; mdl[1] = 4'd0; mdl[2] = 4'd0; mdl[3] = 4'd0;
  endtask

  // expected pins from the select model and the current inputs
  task automatic check_pins(string tag);
    logic [14:0] ev = '0, eo = '0;
    for (int l = 1; l <= 15; l++)
      for (int d = 0; d < 4; d++)
        if (dev_qual[d] && mdl[d] == 4'(l)) begin
          eo[l-1] = 1'b1;
          if (dev_req[d]) ev[l-1] = 1'b1;
        end
    if (smi_en) begin
      eo[1] = 1'b1;
      ev[1] = !smi_req;
    end
    check({tag, " value"}, 32'(irq_o), 32'(ev));
    check({tag, " enable"}, 32'(irq_oe), 32'(eo));
    check("R10 data without enable", 32'(irq_o & ~irq_oe), 32'd0);
  endtask

  task automatic cfg_write(logic [7:0] idx, logic [1:0] dev, logic [7:0] data);
    cfg_we = 1'b1; cfg_index = idx; cfg_dev = dev; cfg_wdata = data;
    step();
    cfg_we = 1'b0;
    if (idx == 8'h70) mdl[dev] = data[3:0];
  endtask

  task automatic cfg_read(logic [7:0] idx, logic [1:0] dev, output logic [7:0] d);
    cfg_index = idx; cfg_dev = dev;
    #1;
    d = cfg_rdata;
  endtask

  task automatic check_all_defaults(string tag);
    logic [7:0] rd;
    for (int d = 0; d < 4; d++) begin
      cfg_read(8'h70, 2'(d), rd);
      check(tag, 32'(rd), (d == 0) ? 32'h06 : 32'h00);
    end
  endtask

  task automatic t_reset();
    load_defaults();
    repeat (3) step();
    check("R9 outputs in reset", 32'(irq_o), 32'd0);
    check("R9 enables in reset", 32'(irq_oe), 32'd0);
    check_all_defaults("R2 main power-on default");
    por_main_n = 1'b1;
    step();
    check_pins("R9 idle after reset");
  endtask

  task automatic t_cfg();
    logic [7:0] rd;
    cfg_write(8'h70, 2'd1, 8'hF3);
    cfg_read(8'h70, 2'd1, rd);
    check("R1 upper bits dropped", 32'(rd), 32'h03);
    cfg_write(8'h71, 2'd1, 8'h05);
    cfg_read(8'h70, 2'd1, rd);
    check("R11 other index write ignored", 32'(rd), 32'h03);
    cfg_read(8'h71, 2'd1, rd);
    check("R11 other index reads zero", 32'(rd), 32'h00);
  endtask

  task automatic t_route();
    logic [3:0] pats [7] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b1011, 4'b1111, 4'b0000};
    cfg_write(8'h70, 2'd0, 8'h06);
    cfg_write(8'h70, 2'd1, 8'h03);
    cfg_write(8'h70, 2'd2, 8'h00);
    cfg_write(8'h70, 2'd3, 8'h0F);
    dev_qual = 4'hF;
    for (int i = 0; i < 7; i++) begin
      dev_req = pats[i];
      step();
      check_pins("R3 R5 R6 routing");
    end
    dev_req = 4'b1000;
    step();
    check("R3 select 15 on top line", 32'(irq_o[14]), 32'd1);
    dev_req = 4'b0100;
    step();
    check("R3 select 0 drives nothing", 32'(irq_o), 32'd0);
  endtask

  task automatic t_qual();
    dev_qual = 4'b0111;
    dev_req = 4'b1000;
    step();
    check("R4 unqualified enable", 32'(irq_oe[14]), 32'd0);
    check("R4 unqualified value", 32'(irq_o[14]), 32'd0);
    dev_req = 4'b1111;
    step();
    check_pins("R4 mixed qualifiers");
    dev_qual = 4'h0;
    step();
    check("R4 no qualifier no enable", 32'(irq_oe), 32'd0);
  endtask

  task automatic t_merge();
    cfg_write(8'h70, 2'd1, 8'h09);
    cfg_write(8'h70, 2'd2, 8'h09);
    dev_qual = 4'hF;
    dev_req = 4'b0100;
    step();
    check("R5 merged line high", 32'(irq_o[8]), 32'd1);
    check_pins("R5 merge one requester");
    dev_req = 4'b0110;
    step();
    check_pins("R5 merge two requesters");
    dev_req = 4'b0000;
    step();
    check("R6 claimed idle enable", 32'(irq_oe[8]), 32'd1);
    check("R6 claimed idle value", 32'(irq_o[8]), 32'd0);
  endtask

  task automatic t_smi();
    cfg_write(8'h70, 2'd1, 8'h02);
    dev_qual = 4'hF;
    dev_req = 4'b0010;
    smi_en = 1'b0;
    step();
    check("R8 line 2 routed", 32'(irq_o[1]), 32'd1);
    check_pins("R8 line 2 routed");
    smi_en = 1'b1; smi_req = 1'b0;
    step();
    check("R7 idle pin high", 32'(irq_o[1]), 32'd1);
    smi_req = 1'b1;
    step();
    check("R7 request pin low despite route", 32'(irq_o[1]), 32'd0);
    check_pins("R7 shared pin");
    dev_qual = 4'h0;
    step();
    check("R7 pin enabled without claim", 32'(irq_oe[1]), 32'd1);
    smi_en = 1'b0; smi_req = 1'b0;
    step();
    check_pins("R8 released pin");
  endtask

  task automatic t_latency();
    dev_qual = 4'b0001;
    dev_req = 4'b0000;
    cfg_write(8'h70, 2'd0, 8'h06);
    step();
    dev_req = 4'b0001;
    #1;
    check("R9 no change before edge", 32'(irq_o[5]), 32'd0);
    step();
    check("R9 change one edge later", 32'(irq_o[5]), 32'd1);
    dev_req = 4'b0000;
  endtask

  task automatic t_resets();
    cfg_write(8'h70, 2'd0, 8'h0A);
    cfg_write(8'h70, 2'd2, 8'h05);
    soft_rst = 1'b1;
    step();
    soft_rst = 1'b0;
    load_defaults();
    check_all_defaults("R2 soft reset default");
    cfg_write(8'h70, 2'd3, 8'h07);
    por_stby_n = 1'b0;
    #1;
    load_defaults();
    check_all_defaults("R2 standby reset default");
    check("R9 standby reset clears enables", 32'(irq_oe), 32'd0);
    step();
    por_stby_n = 1'b1;
    cfg_write(8'h70, 2'd1, 8'h0C);
    bus_rst_n = 1'b0;
    #1;
    load_defaults();
    check_all_defaults("R2 bus reset default");
    step();
    bus_rst_n = 1'b1;
    step();
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_cfg();
    t_route();
    t_qual();
    t_merge();
    t_smi();
    t_latency();
    t_resets();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule